// File: doc/BRIEF.md
# Unsigned Running-Sum Accumulator with Sticky Carry Flag

The block holds a running total of unsigned input words. On each rising clock edge it either adds the input word to the total, sets the total to zero, or leaves the total as it is. The total wraps modulo 2^WIDTH when the sum does not fit. A registered flag records that a carry came out of any addition since the last clear or reset.

A consumer drives `add_i` to fold `data_i` into the total, or drives `clr_i` to start a new run. After a run it reads `total_o`. If `carry_seen_o` is set, the true sum was larger than the total shows. The reset is asynchronous and active low. `clr_i` is the synchronous clear.

Top module: `acc_top`

## Requirements
- R1: While `rst_ni` is low, `total_o` and `carry_seen_o` are 0.
- R2: On a rising edge with `add_i`=1 and `clr_i`=0, `total_o` becomes (previous `total_o` + `data_i`) mod 2^WIDTH. Both operands are unsigned.
- R3: On a rising edge with `clr_i`=1, `total_o` and `carry_seen_o` become 0. This holds whatever the values of `add_i` and `data_i`, so clear takes priority over add.
- R4: On a rising edge with `add_i`=0 and `clr_i`=0, `total_o` and `carry_seen_o` keep their values, whatever the value of `data_i`.
- R5: An add with `clr_i`=0 whose unsigned sum exceeds 2^WIDTH-1 sets `carry_seen_o` to 1 on that edge. For example, 255 plus 1 gives `total_o`=0 and `carry_seen_o`=1.
- R6: Once `carry_seen_o` is 1, later adds with or without carry leave it at 1. Only a clear or a reset returns it to 0.
- R7: An add whose sum fits in WIDTH bits leaves `carry_seen_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | WIDTH | Unsigned word to add |
| add_i | input | 1 | Add `data_i` to the total on this edge |
| clr_i | input | 1 | Zero the total and the flag (priority over add) |
| total_o | output | WIDTH | Accumulated total, modulo 2^WIDTH |
| carry_seen_o | output | 1 | Sticky flag: a carry occurred since the last clear or reset |

## Verification
Runs of small addends stay below 256 and show that plain addition is correct and that the flag stays low. The sums 255+1 and 200+100 cross the boundary by the smallest and by a large margin. They show that the total keeps the low eight bits of the sum and that the flag is set. Adds that follow an overflow show that the flag is sticky and that the total keeps wrapping. Idle cycles with a changing `data_i`, a clear in the middle of a run, and a clear with add also high separate holding from clearing and show that clear wins over add.

// File: rtl/acc_pkg.sv
package acc_pkg;
  typedef enum logic [1:0] {OP_HOLD, OP_ADD, OP_CLR} acc_op_e;
endpackage

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
(
  input  logic    add_i,
  input  logic    clr_i,
  output acc_op_e op_o
);
  always_comb begin
    if (clr_i)      op_o = OP_CLR;
    else if (add_i) op_o = OP_ADD;
    else            op_o = OP_HOLD;
  end
endmodule

// File: rtl/acc_adder.sv
module acc_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  localparam int XW = WIDTH + 1;
  logic [XW-1:0] wide;
  assign wide   = {1'b0, a_i} + {1'b0, b_i};
  assign sum_o  = wide[WIDTH-1:0];
  assign cout_o = wide[XW-1];
endmodule

// File: rtl/acc_top.sv
module acc_top
  import acc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             add_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] total_o,
  output logic             carry_seen_o
);
  acc_op_e          op;
  logic [WIDTH-1:0] sum;
  logic             cout;
  logic [WIDTH-1:0] total_q;
  logic             flag_q;

  acc_ctrl u_ctrl (.add_i(add_i), .clr_i(clr_i), .op_o(op));

  acc_adder #(.WIDTH(WIDTH)) u_add (
    .a_i(total_q), .b_i(data_i), .sum_o(sum), .cout_o(cout)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      total_q <= '0;
      flag_q  <= 1'b0;
    end else begin
      unique case (op)
        OP_CLR: begin
          total_q <= '0;
          flag_q  <= 1'b0;
        end
        OP_ADD: begin
          total_q <= sum;
          flag_q  <= flag_q | cout;
        end
        default: ;
      endcase
    end
  end

  assign total_o      = total_q;
  assign carry_seen_o = flag_q;

  AST_CLR_ZEROES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (total_o == '0 && !carry_seen_o)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !add_i) |=> ($stable(total_o) && $stable(carry_seen_o))); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (carry_seen_o && !clr_i) |=> carry_seen_o); // R6
  AST_ADD_WRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_i && !clr_i) |=> total_o == WIDTH'($past(total_o) + $past(data_i))); // R2
  AST_CARRY_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_i && !clr_i && ({1'b0, total_o} + {1'b0, data_i}) > (WIDTH+1)'((1 << WIDTH) - 1))
    |=> carry_seen_o); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_i && !clr_i && !carry_seen_o && ({1'b0, total_o} + {1'b0, data_i}) < (WIDTH+1)'(1 << WIDTH))
    |=> !carry_seen_o); // R7
endmodule

// File: tb/sim_acc_top.sv
`timescale 1ns/1ps
module sim_acc_top;
  localparam int W = 8;
  logic clk = 0, rst_ni = 0, add = 0, clr = 0;
  logic [W-1:0] din = '0;
  logic [W-1:0] total;
  logic flag;
  int errors = 0, checks = 0;
  int ref_sum = 0;
  bit ref_flag = 0;

  always #2.5 clk = ~clk;

  acc_top #(.WIDTH(W)) u0 (.clk_i(clk), .rst_ni(rst_ni), .data_i(din),
    .add_i(add), .clr_i(clr), .total_o(total), .carry_seen_o(flag));

  task automatic check(string req);
    checks++;
    if (total !== W'(ref_sum) || flag !== ref_flag) begin
      errors++;
      $display("FAIL %s: total=%0d flag=%0b expected total=%0d flag=%0b",
               req, total, flag, ref_sum, ref_flag);
    end
  endtask

  // one cycle: drive at negedge, edge, then sample at next negedge
  task automatic step(bit a, bit c, logic [W-1:0] d, string req);
    add = a; clr = c; din = d;
    @(posedge clk);
    if (c) begin ref_sum = 0; ref_flag = 0; end
    else if (a) begin
      ref_sum = ref_sum + int'(d);
      if (ref_sum > 255) ref_flag = 1;
      ref_sum = ref_sum % 256;
    end
    @(negedge clk);
    check(req);
  endtask

  task automatic t_reset();
    #1 checks++;
    if (total !== '0 || flag !== 1'b0) begin
      errors++; $display("FAIL R1: total=%0d flag=%0b expected 0 0", total, flag);
    end
    @(negedge clk); rst_ni = 1;
    @(negedge clk); check("R1");
  endtask

  task automatic t_small_run();
    step(1, 0, 8'd10, "R2");
    step(1, 0, 8'd20, "R2");
    step(1, 0, 8'd100, "R7");
    step(0, 0, 8'd77, "R4");
    step(0, 0, 8'd255, "R4");
  endtask

  task automatic t_wrap();
    step(1, 0, 8'd125, "R2");  // total 255
    step(1, 0, 8'd1, "R5");    // 255+1 -> 0, flag
    step(1, 0, 8'd3, "R6");
    step(1, 0, 8'd200, "R6");
    step(1, 0, 8'd100, "R6");  // wraps again
    step(0, 0, 8'd9, "R4");
  endtask

  task automatic t_clear();
    step(1, 1, 8'd50, "R3");   // clear beats add
    step(1, 0, 8'd200, "R2");
    step(1, 0, 8'd100, "R5");
    step(0, 1, 8'd0, "R3");    // clear mid run
    step(1, 0, 8'd255, "R7");
    step(1, 0, 8'd0, "R7");
  endtask

  initial begin
    t_reset();
    t_small_run();
    t_wrap();
    t_clear();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #20000;
    errors++; checks++;
    $display("FAIL watchdog: timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule